// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces data-memory addresses for a signal-processing datapath. It holds eight pointer slots. Each slot has an index, a signed modifier, a buffer length and a buffer base. Each access names one index slot and one modifier slot, and asks for either premodify or postmodify. Premodify emits the modified address and leaves the pointer unchanged. Postmodify emits the current pointer and stores the modified value back.

When the length of the chosen slot is nonzero, the modified pointer is folded back into the window `[base, base+length)`. That window may start at any address. A wrap pulse is raised whenever a postmodify update folds the pointer, so that it can drive a buffer overflow interrupt. Postmodify can also emit the pointer with all of its bits mirrored, which is what FFT reordering needs.

The block has a second full copy of every register. A bank-select input chooses which copy the write port and the access port see, which allows a fast context switch.

Top module: `circ_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, every index, modifier, length and base register in both banks is zero, and `addr_valid`, `wrap_evt` and `addr_out` are zero.
- R2: A write with `wr_kind` 0 loads the index and also loads the base of slot `wr_sel`. Kind 1 loads the modifier and kind 2 loads the length. Kind 3 changes nothing. Writes go to the active bank only.
- R3: A premodify access (`acc_post`=0) outputs the modulo-corrected sum of index and modifier, and leaves the stored index unchanged.
- R4: A postmodify access (`acc_post`=1) outputs the stored index and then stores the modulo-corrected sum of index and modifier.
- R5: With a nonzero length, a sum at or above base+length has the length subtracted, and a sum below base has the length added. The modifier is a two's-complement value with magnitude below the length.
- R6: A zero length gives linear addressing: the sum wraps only modulo 2^AW.
- R7: The base may take any value, with no alignment requirement.
- R8: With `acc_bitrev`=1, a postmodify outputs the index with bit k moved to bit AW-1-k over the full width. `acc_bitrev` has no effect on premodify.
- R9: `alt_bank` selects bank 1 when high and bank 0 when low. Registers of the inactive bank keep their values.
- R10: `wrap_evt` is high for one cycle, together with `addr_valid`, when a postmodify applied the R5 correction. It never rises for a premodify.
- R11: If a kind-0 write and a postmodify hit the same index slot in one cycle, the write wins. The output still shows the old index.
- R12: `addr_out` and `addr_valid` are registered: they appear in the cycle after `acc_en`, and `addr_valid` is low after a cycle without `acc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_bank | input | 1 | Active register bank |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | 0 index, 1 modifier, 2 length, 3 none |
| wr_sel | input | $clog2(NREG) | Slot written |
| wr_data | input | AW | Write value |
| acc_en | input | 1 | Access request |
| acc_post | input | 1 | 1 postmodify, 0 premodify |
| acc_bitrev | input | 1 | Mirror postmodify output |
| acc_isel | input | $clog2(NREG) | Index slot used |
| acc_msel | input | $clog2(NREG) | Modifier slot used |
| addr_out | output | AW | Generated address |
| addr_valid | output | 1 | Address valid |
| wrap_evt | output | 1 | Pointer wrapped |

## Verification
The bench builds the block with AW=16 and the default eight slots. A 16-bit space lets linear pointers cross the top of the address space within a few steps. It also lets random buffer bases cover the whole space, and it keeps every mirrored pattern easy to read. Random reprogramming of both banks, mixed with directed odd-aligned buffers, negative modifiers, slot collisions and ignored write kinds, drives both wrap directions and the bank isolation.

// File: rtl/dag_pkg.sv
// Shared definitions for the circular-buffer address generator.
package dag_pkg;
    typedef enum logic [1:0] {
        WK_INDEX  = 2'd0,
        WK_MODIFY = 2'd1,
        WK_LENGTH = 2'd2,
        WK_SKIP   = 2'd3
    } dag_wkind_e;

    localparam int DAG_BANKS = 2;
endpackage

// File: rtl/dag_regfile.sv
// Two banks of index/modifier/length/base registers.
// Assumes: the bank bit selects the copy seen by both ports; a register
// write to an index slot takes priority over a pointer update to that slot.
module dag_regfile
    import dag_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 8,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bank,
    input  logic          wr_en,
    input  logic [1:0]    wr_kind,
    input  logic [SW-1:0] wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          upd_en,
    input  logic [SW-1:0] upd_sel,
    input  logic [AW-1:0] upd_val,
    input  logic [SW-1:0] rd_isel,
    input  logic [SW-1:0] rd_msel,
    output logic [AW-1:0] rd_idx,
    output logic [AW-1:0] rd_base,
    output logic [AW-1:0] rd_len,
    output logic [AW-1:0] rd_mod
);
    logic [DAG_BANKS-1:0][NREG-1:0][AW-1:0] idx_q;
    logic [DAG_BANKS-1:0][NREG-1:0][AW-1:0] mod_q;
    logic [DAG_BANKS-1:0][NREG-1:0][AW-1:0] len_q;
    logic [DAG_BANKS-1:0][NREG-1:0][AW-1:0] base_q;

    // Register update: pointer write-back first, host write last so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            mod_q  <= '0;
            len_q  <= '0;
            base_q <= '0;
        end else begin
            if (upd_en) begin
                idx_q[bank][upd_sel] <= upd_val;
            end
            if (wr_en) begin
                case (dag_wkind_e'(wr_kind))
                    WK_INDEX: begin
                        idx_q[bank][wr_sel]  <= wr_data;
                        base_q[bank][wr_sel] <= wr_data;
                    end
                    WK_MODIFY: mod_q[bank][wr_sel] <= wr_data;
                    WK_LENGTH: len_q[bank][wr_sel] <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // Read ports for the active bank.
    always_comb begin
        rd_idx  = idx_q[bank][rd_isel];
        rd_base = base_q[bank][rd_isel];
        rd_len  = len_q[bank][rd_isel];
        rd_mod  = mod_q[bank][rd_msel];
    end

    // R3: with no write and no pointer update, no index moves
    a_r3_index_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !upd_en) |=> $stable(idx_q));

    // R2: an index write also lands in the base of the same slot
    a_r2_base_tracks_index: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WK_INDEX) |=>
        (base_q[$past(bank)][$past(wr_sel)] == $past(wr_data)));

    // R2: write kind 3 leaves every register as it was
    a_r2_skip_kind_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WK_SKIP && !upd_en) |=>
        ($stable(idx_q) && $stable(mod_q) && $stable(len_q) && $stable(base_q)));
endmodule

// File: rtl/dag_modulo.sv
// Adds a signed modifier to an index and folds the result into
// [base, base+len) when len is nonzero.
// Assumes: the index lies inside its buffer, |modifier| < len, and the
// buffer does not cross the top of the address space.
module dag_modulo #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] modv,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] nxt,
    output logic          wrapped
);
    logic signed [AW+1:0] sum;
    logic signed [AW+1:0] lo;
    logic signed [AW+1:0] hi;

    // Extended-width sum and window limits, so the comparisons cannot overflow.
    always_comb begin
        sum = $signed({2'b00, idx}) + $signed({{2{modv[AW-1]}}, modv});
        lo  = $signed({2'b00, base});
        hi  = $signed({2'b00, base}) + $signed({2'b00, len});
    end

    // One-step correction back into the window.
    always_comb begin
        nxt     = sum[AW-1:0];
        wrapped = 1'b0;
        if (len != '0) begin
            if (sum >= hi) begin
                nxt     = sum[AW-1:0] - len;
                wrapped = 1'b1;
            end else if (sum < lo) begin
                nxt     = sum[AW-1:0] + len;
                wrapped = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dag_bitrev.sv
// Mirrors an address: bit k of the input becomes bit AW-1-k.
module dag_bitrev #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);
    for (genvar k = 0; k < AW; k++) begin : g_mirror
        assign dout[k] = din[AW-1-k];
    end
endmodule

// File: rtl/circ_addr_gen.sv
// Circular-buffer data address generator: premodify and postmodify access,
// modulo wrap at any base, bit-reversed postmodify output, two register
// banks. Outputs are registered, one cycle after the request.
module circ_addr_gen
    import dag_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 8,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alt_bank,
    input  logic          wr_en,
    input  logic [1:0]    wr_kind,
    input  logic [SW-1:0] wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          acc_en,
    input  logic          acc_post,
    input  logic          acc_bitrev,
    input  logic [SW-1:0] acc_isel,
    input  logic [SW-1:0] acc_msel,
    output logic [AW-1:0] addr_out,
    output logic          addr_valid,
    output logic          wrap_evt
);
    logic [AW-1:0] rd_idx, rd_base, rd_len, rd_mod;
    logic [AW-1:0] nxt, rev_idx;
    logic          wrapped;
    logic          upd_en;

    assign upd_en = acc_en & acc_post;

    dag_regfile #(.AW(AW), .NREG(NREG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank    (alt_bank),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .upd_en  (upd_en),
        .upd_sel (acc_isel),
        .upd_val (nxt),
        .rd_isel (acc_isel),
        .rd_msel (acc_msel),
        .rd_idx  (rd_idx),
        .rd_base (rd_base),
        .rd_len  (rd_len),
        .rd_mod  (rd_mod)
    );

    dag_modulo #(.AW(AW)) u_mod (
        .idx     (rd_idx),
        .modv    (rd_mod),
        .base    (rd_base),
        .len     (rd_len),
        .nxt     (nxt),
        .wrapped (wrapped)
    );

    dag_bitrev #(.AW(AW)) u_rev (
        .din  (rd_idx),
        .dout (rev_idx)
    );

    // Output register: choose the address for the requested mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out   <= '0;
            addr_valid <= 1'b0;
            wrap_evt   <= 1'b0;
        end else begin
            addr_valid <= acc_en;
            wrap_evt   <= upd_en & wrapped;
            if (acc_en) begin
                if (acc_post) addr_out <= acc_bitrev ? rev_idx : rd_idx;
                else          addr_out <= nxt;
            end
        end
    end

    // R12: a request yields a valid address on the next cycle
    a_r12_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> addr_valid);

    // R12: no request, no valid address on the next cycle
    a_r12_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !addr_valid);

    // R10: a wrap pulse only accompanies a postmodify result
    a_r10_wrap_on_post: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |-> (addr_valid && $past(acc_post)));

    // R4: plain postmodify emits the index the register file held
    a_r4_post_emits_index: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_post && !acc_bitrev) |=> (addr_out == $past(rd_idx)));
endmodule

// File: tb/circ_addr_gen_test.sv
`timescale 1ns/1ps
module circ_addr_gen_test;
    localparam int AW   = 16;
    localparam int NREG = 8;
    localparam int SW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alt_bank = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_kind = '0;
    logic [SW-1:0] wr_sel = '0;
    logic [AW-1:0] wr_data = '0;
    logic          acc_en = 1'b0;
    logic          acc_post = 1'b0;
    logic          acc_bitrev = 1'b0;
    logic [SW-1:0] acc_isel = '0;
    logic [SW-1:0] acc_msel = '0;
    logic [AW-1:0] addr_out;
    logic          addr_valid;
    logic          wrap_evt;

    always #4 clk = ~clk;

    circ_addr_gen #(.AW(AW), .NREG(NREG)) uut (
        .clk(clk), .rst_n(rst_n), .alt_bank(alt_bank),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel), .wr_data(wr_data),
        .acc_en(acc_en), .acc_post(acc_post), .acc_bitrev(acc_bitrev),
        .acc_isel(acc_isel), .acc_msel(acc_msel),
        .addr_out(addr_out), .addr_valid(addr_valid), .wrap_evt(wrap_evt)
    );

    int errors = 0;
    int checks = 0;
    int bk = 0;
    logic [AW-1:0] m_idx  [2][NREG];
    logic [AW-1:0] m_mod  [2][NREG];
    logic [AW-1:0] m_len  [2][NREG];
    logic [AW-1:0] m_base [2][NREG];

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] rev(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int k = 0; k < AW; k++) r[k] = v[AW-1-k];
        return r;
    endfunction

    function automatic logic [AW-1:0] step(input logic [AW-1:0] i, input logic [AW-1:0] m,
                                           input logic [AW-1:0] l, input logic [AW-1:0] b,
                                           output bit w);
        longint s, hi;
        s  = longint'(i) + longint'($signed(m));
        hi = longint'(b) + longint'(l);
        w  = 1'b0;
        if (l != 0) begin
            if (s >= hi) begin s = s - longint'(l); w = 1'b1; end
            else if (s < longint'(b)) begin s = s + longint'(l); w = 1'b1; end
        end
        return s[AW-1:0];
    endfunction

    // Register write; called at a falling edge, returns at the next one.
    task automatic wr(input int kind, input int sel, input logic [AW-1:0] d);
        wr_en = 1'b1; wr_kind = kind[1:0]; wr_sel = sel[SW-1:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (kind)
            0: begin m_idx[bk][sel] = d; m_base[bk][sel] = d; end
            1: m_mod[bk][sel] = d;
            2: m_len[bk][sel] = d;
            default: ;
        endcase
    endtask

    // Access with an optional same-slot index write (R11).
    task automatic acc(input bit post, input int is, input int ms, input bit br,
                       input string tag, input bit cw = 1'b0, input logic [AW-1:0] cwd = '0);
        bit w;
        logic [AW-1:0] nx, ea;
        nx = step(m_idx[bk][is], m_mod[bk][ms], m_len[bk][is], m_base[bk][is], w);
        ea = post ? (br ? rev(m_idx[bk][is]) : m_idx[bk][is]) : nx;
        acc_en = 1'b1; acc_post = post; acc_bitrev = br;
        acc_isel = is[SW-1:0]; acc_msel = ms[SW-1:0];
        if (cw) begin wr_en = 1'b1; wr_kind = 2'd0; wr_sel = is[SW-1:0]; wr_data = cwd; end
        @(negedge clk);
        acc_en = 1'b0; wr_en = 1'b0;
        chk({tag, " addr"}, addr_out, ea);
        chk("R12 valid", {15'd0, addr_valid}, 16'd1);
        chk({tag, " R10 wrap"}, {15'd0, wrap_evt}, {15'd0, post & w});
        if (post) m_idx[bk][is] = nx;
        if (cw) begin m_idx[bk][is] = cwd; m_base[bk][is] = cwd; end
    endtask

    task automatic program_slot(input int s);
        logic [AW-1:0] l, b, m, mag;
        if ($urandom % 4 == 0) begin
            l = '0; b = AW'($urandom); m = AW'($urandom);
        end else begin
            l   = AW'(1 + $urandom % 200);
            b   = AW'($urandom % (65536 - 256));
            mag = AW'($urandom % l);
            m   = ($urandom % 2 == 1) ? -mag : mag;
        end
        wr(0, s, b);
        wr(2, s, l);
        wr(1, s, m);
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240);
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < NREG; s++) begin
                m_idx[b][s] = '0; m_mod[b][s] = '0; m_len[b][s] = '0; m_base[b][s] = '0;
            end
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {15'd0, addr_valid}, 16'd0);
        chk("R1 reset wrap", {15'd0, wrap_evt}, 16'd0);
        chk("R1 reset addr", addr_out, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        acc(1, 0, 0, 0, "R1 zero regs");
        @(negedge clk);
        chk("R12 idle valid", {15'd0, addr_valid}, 16'd0);

        // R5 R7: odd base 0x1003, length 5, step +3
        wr(0, 1, 16'h1003); wr(2, 1, 16'd5); wr(1, 1, 16'd3);
        acc(1, 1, 1, 0, "R7 post");
        acc(1, 1, 1, 0, "R5 upper wrap");
        chk("R5 wrapped value", m_idx[0][1], 16'h1004);
        acc(1, 1, 1, 0, "R5 after wrap");
        // R5: negative step below base
        wr(0, 2, 16'h2000); wr(2, 2, 16'd4); wr(1, 2, 16'hFFFF);
        acc(1, 2, 2, 0, "R5 lower wrap");
        // R3: premodify folds but does not move the pointer or pulse
        acc(0, 2, 1, 0, "R3 pre fold");
        acc(0, 2, 1, 1, "R8 pre ignores mirror");
        acc(1, 2, 2, 0, "R3 index kept");
        // R6: linear crossing of the top of the space
        wr(0, 3, 16'hFFFE); wr(2, 3, 16'd0); wr(1, 3, 16'd3);
        acc(1, 3, 3, 0, "R6 linear");
        chk("R6 wrapped linear", m_idx[0][3], 16'h0001);
        acc(1, 3, 3, 0, "R6 linear next");
        // R8: mirror of 0x0001 is 0x8000
        wr(0, 4, 16'h0001); wr(2, 4, 16'd0); wr(1, 4, 16'd1);
        acc(1, 4, 4, 1, "R8 mirror");
        acc(1, 4, 4, 0, "R4 post after mirror");
        // R9: bank 1 is untouched by bank 0 writes
        alt_bank = 1'b1; bk = 1;
        acc(1, 1, 1, 0, "R9 alt bank zero");
        wr(0, 1, 16'h0555);
        acc(1, 1, 1, 0, "R9 alt bank write");
        alt_bank = 1'b0; bk = 0;
        acc(0, 1, 1, 0, "R9 primary kept");
        // R2: write kind 3 changes nothing
        wr(3, 1, 16'hABCD);
        acc(1, 1, 1, 0, "R2 kind3 ignored");
        // R11: write and postmodify on the same slot
        wr(0, 5, 16'h0100); wr(1, 5, 16'h0010);
        acc(1, 5, 5, 0, "R11 collision", 1'b1, 16'h0300);
        acc(1, 5, 5, 0, "R11 write wins");

        // Constrained random mix
        for (int s = 0; s < NREG; s++) program_slot(s);
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom % 32);
            if (r == 0) begin
                alt_bank = ~alt_bank; bk = int'(alt_bank);
            end else if (r < 4) begin
                program_slot(int'($urandom % NREG));
            end else if (r == 4) begin
                wr(3, int'($urandom % NREG), AW'($urandom));
            end else begin
                int s;
                s = int'($urandom % NREG);
                acc(1'($urandom), s, s, 1'($urandom), "R4 R5 random");
            end
        end
        @(negedge clk);
        chk("R12 final idle", {15'd0, addr_valid}, 16'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R12: got no finish expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule